// File: doc/BRIEF.md
# Two-Step Flash Conversion Sequencer

This block is the digital control and encoding half of a two-step subranging analog-to-digital converter. A single bank of 33 comparators, spread over a 32-segment ladder, is read twice per conversion. The first reading happens while the input is held and gives the coarse half. The second reading is taken after the residue amplifier has produced the magnified remainder, and gives the fine half. The block paces the comparator and amplifier phases, counts the comparator word with one shared encoder, and joins the two 5-bit halves into a 10-bit two's-complement sample with a separate out-of-range flag.

A conversion takes three clocks: a hold clock, a residue-settle clock and a fine-compare clock. With the start input held high the conversions follow one another with no gap, so a new sample is held while the previous answer is being moved to the output. The coarse half sits in a first-level register. The finished word sits in a second-level register that only changes when a conversion completes. After reset the block waits a fixed number of initialization clocks before it honours a start.

Top module: `twostep_flash_seq`

## Requirements
- R1: While reset is active and in the first clock after it, hold_n is 1, every phase strobe is 0, res_valid is 0, and res_data and res_ovr are 0.
- R2: For INIT_CYC (default 6) clocks after reset the start input is ignored and hold_n stays 1. With start held high from reset release, hold_n is first 0 in the clock after the 7th rising edge.
- R3: Each conversion drives hold_n low for exactly one clock, then high for the two clocks that follow.
- R4: coarse_cmp is 1 only in the hold clock. resid_az is 1 only in the second clock. fine_cmp is 1 only in the third clock. resid_amp is 1 in the second and third clocks.
- R5: With a coarse count c of ones (1 to 32), taken in the hold clock, the upper five result bits are c-1 with their top bit inverted. With a fine count f, taken in the third clock, the lower five bits are f-1, or 0 when f is 0, or 31 when f is 33. Both counts are taken at the rising edge that ends their clock.
- R6: res_valid is 1 for exactly the one clock after the third clock, and res_data and res_ovr show the new sample in that clock.
- R7: A coarse count of 0 gives res_data 0x200 with res_ovr 1. A coarse count of 33 gives res_data 0x1FF with res_ovr 1. Any other coarse count gives res_ovr 0.
- R8: A comparator word with holes (non-thermometer) is encoded by the number of ones it holds.
- R9: If start is 1 at the edge ending the third clock, the next hold clock follows at once, giving one sample every three clocks.
- R10: res_data and res_ovr keep their value in every clock in which res_valid is 0, including while a following conversion is under way.
- R11: If start is 0 at the edge ending the third clock, the block goes idle and hold_n stays 1 until start is seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_start | input | 1 | Start request, sampled on rising edges; held high for back-to-back conversions |
| therm_in | input | 33 | Comparator outputs, one bit per comparator |
| hold_n | output | 1 | Track/hold control, low during the hold clock |
| coarse_cmp | output | 1 | Comparators sample and compare the held input |
| resid_az | output | 1 | Comparators auto-zero on the residue |
| resid_amp | output | 1 | Residue amplifier is amplifying |
| fine_cmp | output | 1 | Comparators compare the residue |
| res_valid | output | 1 | One-clock pulse when a new sample is on res_data |
| res_data | output | 10 | Two's-complement sample, bit 9 is the sign |
| res_ovr | output | 1 | Out of range; direction given by res_data[9] |

## Verification
The assertions assume that conv_start and therm_in change only away from the rising clock edge, and that therm_in is meaningful only in the hold and fine-compare clocks. The bench drives every input on the falling edge. It loads the coarse word during the hold clock and the fine word during the third clock, and it puts a different, unrelated pattern on therm_in in the middle clock. This makes a capture taken in the wrong phase produce a wrong sample.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HOLD  = 2'd1,
    PH_RESID = 2'd2,
    PH_FINE  = 2'd3
  } phase_e;

  // Coarse segment index (count-1) in offset binary; flipping the top bit
  // turns it into the signed upper half.
  function automatic int coarse_upper(input int cnt, input int hw);
    return (cnt - 1) ^ (1 << (hw - 1));
  endfunction

  // Fine half: count-1, clamped to the representable range.
  function automatic int fine_lower(input int cnt, input int hw);
    if (cnt <= 0)             return 0;
    else if (cnt > (1 << hw)) return (1 << hw) - 1;
    else                      return cnt - 1;
  endfunction

endpackage

// File: rtl/tsf_phase_seq.sv
module tsf_phase_seq #(
  parameter int INIT_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic hold_n,
  output logic coarse_cmp,
  output logic resid_az,
  output logic resid_amp,
  output logic fine_cmp
);
  import tsf_pkg::*;

  localparam int IW = $clog2(INIT_CYC + 1);

  logic [IW-1:0] init_q;
  phase_e        ph_q;
  logic          ready;

  assign ready = (init_q == IW'(INIT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      ph_q   <= PH_IDLE;
    end else if (!ready) begin
      init_q <= init_q + 1'b1;
    end else begin
      case (ph_q)
        PH_IDLE:  if (start) ph_q <= PH_HOLD;
        PH_HOLD:  ph_q <= PH_RESID;
        PH_RESID: ph_q <= PH_FINE;
        default:  ph_q <= start ? PH_HOLD : PH_IDLE;
      endcase
    end
  end

  assign hold_n     = (ph_q != PH_HOLD);
  assign coarse_cmp = (ph_q == PH_HOLD);
  assign resid_az   = (ph_q == PH_RESID);
  assign fine_cmp   = (ph_q == PH_FINE);
  assign resid_amp  = resid_az | fine_cmp;

  // R3: hold lasts a single clock
  p_hold_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> hold_n);
  // R2: no hold before initialization completes
  p_init_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> hold_n);
  // R4: phase order hold -> residue auto-zero -> fine compare
  p_hold_then_az_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_cmp |=> resid_az);
  p_az_then_fine_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resid_az |=> fine_cmp);

endmodule

// File: rtl/tsf_flash_enc.sv
module tsf_flash_enc #(
  parameter int HALF_W = 5,
  parameter int NCMP   = (1 << HALF_W) + 1
) (
  input  logic [NCMP-1:0]   therm,
  output logic [HALF_W-1:0] upper,
  output logic [HALF_W-1:0] lower,
  output logic              ovr_pos,
  output logic              ovr_neg
);
  localparam int CNT_W = $clog2(NCMP + 1);

  logic [CNT_W-1:0] ones_cnt;

  // Counting ones tolerates bubbles in the comparator word.
  always_comb begin
    ones_cnt = '0;
    for (int i = 0; i < NCMP; i++) ones_cnt = ones_cnt + CNT_W'(therm[i]);
  end

  assign upper   = HALF_W'(tsf_pkg::coarse_upper(int'(ones_cnt), HALF_W));
  assign lower   = HALF_W'(tsf_pkg::fine_lower(int'(ones_cnt), HALF_W));
  assign ovr_neg = (ones_cnt == '0);
  assign ovr_pos = (ones_cnt == CNT_W'(NCMP));

endmodule

// File: rtl/tsf_result_latch.sv
module tsf_result_latch #(
  parameter int HALF_W = 5,
  parameter int RES_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_coarse,
  input  logic              cap_fine,
  input  logic [HALF_W-1:0] upper,
  input  logic [HALF_W-1:0] lower,
  input  logic              ovr_pos,
  input  logic              ovr_neg,
  output logic [RES_W-1:0]  res_data,
  output logic              res_ovr,
  output logic              res_valid
);
  // first level: coarse half and its range flags
  logic [HALF_W-1:0] up_q;
  logic              op_q, on_q;
  logic [RES_W-1:0]  merged;

  always_comb begin
    if (op_q)      merged = {1'b0, {(RES_W-1){1'b1}}};
    else if (on_q) merged = {1'b1, {(RES_W-1){1'b0}}};
    else           merged = {up_q, lower};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      op_q <= 1'b0;
      on_q <= 1'b0;
    end else if (cap_coarse) begin
      up_q <= upper;
      op_q <= ovr_pos;
      on_q <= ovr_neg;
    end
  end

  // second level: full word, updated only at the end of a conversion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_ovr   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= cap_fine;
      if (cap_fine) begin
        res_data <= merged;
        res_ovr  <= op_q | on_q;
      end
    end
  end

  // R10: output word holds between completions
  p_data_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_data) && $stable(res_ovr)));
  // R7: out-of-range always carries a full-scale code
  p_ovr_fullscale_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovr |-> (res_data == {1'b0, {(RES_W-1){1'b1}}} ||
                 res_data == {1'b1, {(RES_W-1){1'b0}}}));

endmodule

// File: rtl/twostep_flash_seq.sv
module twostep_flash_seq #(
  parameter int HALF_W   = 5,
  parameter int INIT_CYC = 6,
  parameter int NCMP     = (1 << HALF_W) + 1,
  parameter int RES_W    = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic [NCMP-1:0]  therm_in,
  output logic             hold_n,
  output logic             coarse_cmp,
  output logic             resid_az,
  output logic             resid_amp,
  output logic             fine_cmp,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_ovr
);
  logic [HALF_W-1:0] enc_upper, enc_lower;
  logic              enc_pos, enc_neg;

  tsf_phase_seq #(.INIT_CYC(INIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(conv_start),
    .hold_n(hold_n), .coarse_cmp(coarse_cmp), .resid_az(resid_az),
    .resid_amp(resid_amp), .fine_cmp(fine_cmp)
  );

  // one encoder serves both passes
  tsf_flash_enc #(.HALF_W(HALF_W), .NCMP(NCMP)) u_enc (
    .therm(therm_in), .upper(enc_upper), .lower(enc_lower),
    .ovr_pos(enc_pos), .ovr_neg(enc_neg)
  );

  tsf_result_latch #(.HALF_W(HALF_W), .RES_W(RES_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .cap_coarse(coarse_cmp), .cap_fine(fine_cmp),
    .upper(enc_upper), .lower(enc_lower), .ovr_pos(enc_pos), .ovr_neg(enc_neg),
    .res_data(res_data), .res_ovr(res_ovr), .res_valid(res_valid)
  );

  // R6: completion follows the fine compare by one clock, as a single pulse
  p_valid_after_fine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fine_cmp |=> res_valid);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

endmodule

// File: tb/sim_twostep_flash_seq.sv
`timescale 1ns/1ps
module sim_twostep_flash_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic [32:0] therm_in = '0;
  logic        hold_n, coarse_cmp, resid_az, resid_amp, fine_cmp;
  logic        res_valid, res_ovr;
  logic [9:0]  res_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [9:0] prev_data = '0;
  logic       prev_ovr = 1'b0;

  always #2.5 clk = ~clk;

  twostep_flash_seq u0 (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .therm_in(therm_in),
    .hold_n(hold_n), .coarse_cmp(coarse_cmp), .resid_az(resid_az),
    .resid_amp(resid_amp), .fine_cmp(fine_cmp), .res_valid(res_valid),
    .res_data(res_data), .res_ovr(res_ovr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [32:0] mk(input int c, input bit bub);
    logic [32:0] v = '0;
    for (int i = 0; i < c; i++) v[i] = 1'b1;
    if (bub && c >= 2 && c <= 32) begin
      v[c-2] = 1'b0;
      v[c]   = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [10:0] expect_word(input int c, input int f);
    int up, fn;
    if (c == 0)  return {1'b1, 10'h200};
    if (c == 33) return {1'b1, 10'h1FF};
    up = (c - 1) ^ 16;
    fn = (f == 0) ? 0 : ((f > 32) ? 31 : f - 1);
    return {1'b0, 10'(up * 32 + fn)};
  endfunction

  // Called at a falling edge inside a hold clock.
  task automatic run_conv(input int c, input int f, input bit bub, input bit keep,
                          input string tag);
    logic [10:0] e = expect_word(c, f);
    chk({tag, " R3 hold low"}, hold_n, 0);
    chk({tag, " R4 coarse strobe"}, {coarse_cmp, resid_az, resid_amp, fine_cmp}, 4'b1000);
    therm_in = mk(c, bub);
    @(posedge clk); @(negedge clk);
    chk({tag, " R3 track"}, hold_n, 1);
    chk({tag, " R4 residue az"}, {coarse_cmp, resid_az, resid_amp, fine_cmp}, 4'b0110);
    chk({tag, " R10 held data"}, {res_ovr, res_data}, {prev_ovr, prev_data});
    therm_in = 33'h0_5A5A_5A5A;
    @(posedge clk); @(negedge clk);
    chk({tag, " R3 track2"}, hold_n, 1);
    chk({tag, " R4 fine strobe"}, {coarse_cmp, resid_az, resid_amp, fine_cmp}, 4'b0011);
    therm_in   = mk(f, bub);
    conv_start = keep;
    @(posedge clk); @(negedge clk);
    chk({tag, " R6 valid"}, res_valid, 1);
    chk({tag, " R5/R7/R8 word"}, {res_ovr, res_data}, e);
    chk({tag, " R9/R11 next hold"}, hold_n, !keep);
    prev_data = e[9:0];
    prev_ovr  = e[10];
  endtask

  task automatic kick();
    conv_start = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset outs", {hold_n, coarse_cmp, resid_az, resid_amp, fine_cmp, res_valid, res_ovr}, 7'b1000000);
    chk("R1 reset data", res_data, 0);
  endtask

  task automatic t_init();
    conv_start = 1'b1;
    rst_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); @(negedge clk);
      chk($sformatf("R2 init quiet %0d", k), hold_n, 1);
    end
    @(posedge clk); @(negedge clk);
    run_conv(17, 1, 0, 0, "zero");
  endtask

  task automatic t_codes();
    kick(); run_conv(16, 32, 0, 0, "minus1");
    kick(); run_conv(32, 32, 0, 0, "posfs");
    kick(); run_conv(1, 1, 0, 0, "negfs");
    kick(); run_conv(20, 6, 0, 0, "mid");
    kick(); run_conv(17, 0, 0, 0, "fine0");
    kick(); run_conv(17, 33, 0, 0, "fine33");
  endtask

  task automatic t_ovr();
    kick(); run_conv(0, 10, 0, 0, "R7 neg ovr");
    kick(); run_conv(33, 10, 0, 0, "R7 pos ovr");
  endtask

  task automatic t_bubble();
    kick(); run_conv(20, 6, 1, 0, "R8 bubble");
  endtask

  task automatic t_continuous();
    kick();
    run_conv(5, 9, 0, 1, "R9 c1");
    run_conv(30, 2, 0, 1, "R9 c2");
    run_conv(0, 3, 0, 0, "R9 c3");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R11 idle hold", hold_n, 1);
      chk("R6 no valid", res_valid, 0);
      chk("R10 idle data", {res_ovr, res_data}, {prev_ovr, prev_data});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_init();
    t_codes();
    t_ovr();
    t_bubble();
    t_continuous();
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule